// File: doc/BRIEF.md
# Keyed-Start Watchdog Timer

This block is a watchdog timer that sits on a simple word-addressed register bus. A free-running up-counter advances on a slow reference tick. The tick rate is nominally 32 kHz, and the `tick_en` input stands in for that slow clock. An optional power-of-two prescaler can slow the counter further. When the counter passes its all-ones value, the block raises a one-cycle reset request and reloads the counter from the load register.

Software keeps the system alive by writing the trigger register with a value different from the last accepted one. Each such write reloads the counter. Starting and stopping the counter each take an ordered pair of key words written to the key register.

Every write to a writable register is posted. It takes effect on the third slow tick after the bus cycle, and the status register shows a per-register busy bit until then.

The bus has no handshake. Writes complete in one clock cycle, and reads are combinational from `bus_addr`. No data stream exists, so no valid/ready interface is present.

Top module: `wdog_seq_top`

## Requirements
- R1: After reset the status word, the run flag (address 6, bit 0), the count (address 5) and `wdt_reset_req` are all zero.
- R2: A bus write to the control (address 0), load (address 1), trigger (address 2) or key (address 3) register sets status bit 0, 1, 2 or 3 respectively (status at address 4). The bit is set from the cycle after the write. It clears on the third `tick_en` pulse after the write cycle, on the same edge at which the written value takes effect. Control and load read back their committed value.
- R3: A write to a register whose status bit is still set is dropped, and the staged value is kept.
- R4: Committing key 0x0000BBBB and then key 0x00004444 sets the run flag.
- R5: Committing key 0x0000AAAA and then key 0x00005555 clears the run flag.
- R6: A key word that does not continue the sequence in progress discards it. 0xBBBB or 0xAAAA then opens a new sequence, and any other word returns to idle.
- R7: While running, the count rises by one per prescaled tick. While stopped it holds, unless a trigger reloads it.
- R8: Control bit (RATIO_W+2) enables the prescaler, and control bits [RATIO_W+1:2] give the ratio r. When enabled, the count advances once per 2^r ticks. When disabled, it advances once per tick whatever r is.
- R9: A prescaled tick while running at count all-ones pulses `wdt_reset_req` for exactly one cycle and reloads the low CNT_W bits of the load register.
- R10: A committed trigger value that differs from the last accepted one reloads the count from the load register and becomes the new last value (readable at address 2). A value equal to the last one is ignored. The last value is zero after reset.
- R11: When a reloading trigger commits on the same edge as an overflow, the count reloads and no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse per slow reference tick |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| wdt_reset_req | output | 1 | One-cycle reset request on overflow |

## Verification
Two events can fall on the same edge: a trigger commit that reloads the counter, and the overflow that would raise a reset request. The bench advances the counter to two below all-ones and posts a fresh trigger value. The third tick, which commits the trigger, then also carries the counter past all-ones. The bench counts request pulses on every falling edge, and judges the case by the count holding the load value with no pulse seen.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int BUS_W = 32;
  localparam int NSLOT = 4;

  // writable slot indices double as their bus addresses and status bit positions
  localparam int SLOT_CTRL = 0;
  localparam int SLOT_LOAD = 1;
  localparam int SLOT_TRIG = 2;
  localparam int SLOT_KEY  = 3;

  localparam logic [2:0] ADR_STATUS = 3'd4;
  localparam logic [2:0] ADR_COUNT  = 3'd5;
  localparam logic [2:0] ADR_RUN    = 3'd6;

  localparam logic [BUS_W-1:0] KEY_ARM_1 = 32'h0000_BBBB;
  localparam logic [BUS_W-1:0] KEY_ARM_2 = 32'h0000_4444;
  localparam logic [BUS_W-1:0] KEY_OFF_1 = 32'h0000_AAAA;
  localparam logic [BUS_W-1:0] KEY_OFF_2 = 32'h0000_5555;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_ARMED = 2'd1,
    KS_OFFED = 2'd2
  } key_state_e;
endpackage

// File: rtl/wdt_post_slot.sv
module wdt_post_slot #(
  parameter int DW  = 32,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  output logic          pending,
  output logic          commit,
  output logic [DW-1:0] staged
);
  localparam int AGE_W = (LAT < 2) ? 1 : $clog2(LAT);

  logic [AGE_W-1:0] age;

  assign commit = pending && tick && (age == AGE_W'(LAT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      age     <= '0;
      staged  <= '0;
    end else if (commit) begin
      pending <= 1'b0;
      age     <= '0;
    end else if (pending && tick) begin
      age <= age + AGE_W'(1);
    end else if (!pending && wr_stb) begin
      pending <= 1'b1;
      age     <= '0;
      staged  <= wr_data;
    end
  end

  // R2
  pend_clear_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(tick));

  // R3
  staged_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> $stable(staged));
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_in,
  input  logic          en,
  input  logic [RW-1:0] ratio,
  output logic          tick_out
);
  localparam int DVW = (1 << RW) - 1;

  logic [DVW-1:0] div;
  logic [DVW-1:0] limit;

  always_comb limit = (DVW'(1) << ratio) - DVW'(1);

  assign tick_out = tick_in && (!en || (div >= limit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div <= '0;
    end else if (!en) begin
      div <= '0;
    end else if (tick_in) begin
      div <= tick_out ? '0 : div + DVW'(1);
    end
  end

  // R8
  prescale_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> tick_in);
endmodule

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [BUS_W-1:0] word,
  output logic             running
);
  key_state_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= KS_IDLE;
      running <= 1'b0;
    end else if (commit) begin
      if (st == KS_ARMED && word == KEY_ARM_2) begin
        running <= 1'b1;
        st      <= KS_IDLE;
      end else if (st == KS_OFFED && word == KEY_OFF_2) begin
        running <= 1'b0;
        st      <= KS_IDLE;
      end else if (word == KEY_ARM_1) begin
        st <= KS_ARMED;
      end else if (word == KEY_OFF_1) begin
        st <= KS_OFFED;
      end else begin
        st <= KS_IDLE;
      end
    end
  end

  // R4
  run_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(running));

  // R4
  rise_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> ($past(st) == KS_ARMED && $past(word) == KEY_ARM_2));

  // R5
  fall_needs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> ($past(st) == KS_OFFED && $past(word) == KEY_OFF_2));
endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             run,
  input  logic [CW-1:0]    load_val,
  input  logic             trig_commit,
  input  logic [BUS_W-1:0] trig_word,
  output logic [CW-1:0]    cnt,
  output logic [BUS_W-1:0] last_trig,
  output logic             ovf
);
  logic trig_new;
  logic wrap;

  assign trig_new = trig_commit && (trig_word != last_trig);
  assign wrap     = run && step && (cnt == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      last_trig <= '0;
      ovf       <= 1'b0;
    end else begin
      ovf <= wrap && !trig_new;
      if (trig_new) begin
        cnt       <= load_val;
        last_trig <= trig_word;
      end else if (wrap) begin
        cnt <= load_val;
      end else if (run && step) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R9
  ovf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (cnt == $past(load_val)));

  // R9
  ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !ovf);

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !trig_commit) |=> $stable(cnt));

  // R10
  dup_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_commit && trig_word == last_trig && !(run && step)) |=> $stable(cnt));

  // R11
  trig_beats_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_commit && trig_word != last_trig) |=> !ovf);
endmodule

// File: rtl/wdog_seq_top.sv
module wdog_seq_top
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int RATIO_W  = 3,
  parameter int POST_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             wdt_reset_req
);
  localparam int RATIO_LSB = 2;
  localparam int PRE_EN_BIT = RATIO_LSB + RATIO_W;

  logic [NSLOT-1:0] pend;
  logic [NSLOT-1:0] commit;
  logic [BUS_W-1:0] staged [NSLOT];

  logic [BUS_W-1:0] ctrl_q;
  logic [BUS_W-1:0] load_q;
  logic [BUS_W-1:0] last_trig;
  logic [CNT_W-1:0] cnt;
  logic             running;
  logic             step;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic stb;
    assign stb = bus_wr && (bus_addr == 3'(i));

    wdt_post_slot #(.DW(BUS_W), .LAT(POST_LAT)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_en),
      .wr_stb  (stb),
      .wr_data (bus_wdata),
      .pending (pend[i]),
      .commit  (commit[i]),
      .staged  (staged[i])
    );

    // R2
    pend_set_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[i]) |-> ($past(bus_wr) && $past(bus_addr) == 3'(i)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
    end else begin
      if (commit[SLOT_CTRL]) ctrl_q <= staged[SLOT_CTRL];
      if (commit[SLOT_LOAD]) load_q <= staged[SLOT_LOAD];
    end
  end

  wdt_prescale #(.RW(RATIO_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (tick_en),
    .en       (ctrl_q[PRE_EN_BIT]),
    .ratio    (ctrl_q[RATIO_LSB +: RATIO_W]),
    .tick_out (step)
  );

  wdt_unlock u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (commit[SLOT_KEY]),
    .word    (staged[SLOT_KEY]),
    .running (running)
  );

  wdt_count #(.CW(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (step),
    .run         (running),
    .load_val    (load_q[CNT_W-1:0]),
    .trig_commit (commit[SLOT_TRIG]),
    .trig_word   (staged[SLOT_TRIG]),
    .cnt         (cnt),
    .last_trig   (last_trig),
    .ovf         (wdt_reset_req)
  );

  always_comb begin
    case (bus_addr)
      3'(SLOT_CTRL): bus_rdata = ctrl_q;
      3'(SLOT_LOAD): bus_rdata = load_q;
      3'(SLOT_TRIG): bus_rdata = last_trig;
      ADR_STATUS:    bus_rdata = BUS_W'(pend);
      ADR_COUNT:     bus_rdata = BUS_W'(cnt);
      ADR_RUN:       bus_rdata = BUS_W'(running);
      default:       bus_rdata = '0;
    endcase
  end

  // R1
  status_idle_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (pend == '0 && !wdt_reset_req));
endmodule

// File: tb/sim_wdog_seq_top.sv
module sim_wdog_seq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  bit done = 0;
  logic [31:0] tv = 32'h100;

  always #4 clk = ~clk;

  wdog_seq_top #(.CNT_W(8), .RATIO_W(3), .POST_LAT(3)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .wdt_reset_req(rst_req)
  );

  always @(negedge clk) if (rst_n && rst_req) pulses++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic post(input logic [2:0] a, input logic [31:0] d);
    wr_reg(a, d);
    tick(3);
  endtask

  task automatic fresh_trig();
    tv = tv + 1;
    post(3'd2, tv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] c0;
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd4, v); chk("R1 status", v, 0);
    rd(3'd6, v); chk("R1 run", v, 0);
    rd(3'd5, v); chk("R1 count", v, 0);
    chk("R1 pulses", pulses, 0);

    // R2 posted load write
    wr_reg(3'd1, 32'hF0);
    rd(3'd4, v); chk("R2 load pending set", v, 32'h2);
    tick(2);
    rd(3'd4, v); chk("R2 still pending", v, 32'h2);
    rd(3'd1, v); chk("R2 load not yet", v, 0);
    tick(1);
    rd(3'd4, v); chk("R2 cleared", v, 0);
    rd(3'd1, v); chk("R2 load value", v, 32'hF0);

    // R3 write while pending dropped
    wr_reg(3'd1, 32'h11);
    wr_reg(3'd1, 32'h22);
    tick(3);
    rd(3'd1, v); chk("R3 second write dropped", v, 32'h11);
    post(3'd1, 32'hF0);

    // R4 start sequence
    post(3'd3, 32'hBBBB);
    rd(3'd6, v); chk("R4 half sequence", v, 0);
    post(3'd3, 32'h4444);
    rd(3'd6, v); chk("R4 running", v, 1);

    // R10 trigger equal to reset value 0 ignored
    rd(3'd5, c0);
    post(3'd2, 32'h0);
    rd(3'd5, v); chk("R10 zero trigger ignored", v, c0 + 3);
    post(3'd2, 32'h1);
    rd(3'd5, v); chk("R10 fresh trigger reloads", v, 32'hF0);
    rd(3'd2, v); chk("R10 last value", v, 32'h1);
    post(3'd2, 32'h1);
    rd(3'd5, v); chk("R10 repeat ignored", v, 32'hF3);

    // R9 overflow sweep over load values
    for (int li = 0; li < 4; li++) begin
      logic [31:0] ld;
      ld = (li == 0) ? 32'hF0 : (li == 1) ? 32'hF8 : (li == 2) ? 32'hFC : 32'hFF;
      post(3'd1, ld);
      fresh_trig();
      rd(3'd5, v); chk("R10 reload from load", v, ld);
      p0 = pulses;
      tick(255 - int'(ld));
      rd(3'd5, v); chk("R9 at all-ones", v, 32'hFF);
      chk("R9 no early pulse", pulses, p0);
      tick(1);
      rd(3'd5, v); chk("R9 reloaded after wrap", v, ld);
      chk("R9 one pulse", pulses, p0 + 1);
    end

    // R11 trigger commit coincides with overflow
    post(3'd1, 32'hF0);
    fresh_trig();
    tick(13);
    rd(3'd5, v); chk("R11 setup", v, 32'hFD);
    p0 = pulses;
    tv = tv + 1;
    wr_reg(3'd2, tv);
    tick(2);
    rd(3'd5, v); chk("R11 at all-ones", v, 32'hFF);
    tick(1);
    rd(3'd5, v); chk("R11 reload wins", v, 32'hF0);
    chk("R11 no reset request", pulses, p0);

    // R8 prescaler sweep
    post(3'd1, 32'h0);
    for (int r = 0; r < 4; r++) begin
      post(3'd0, 32'h20 | (r << 2));
      fresh_trig();
      tick(16);
      rd(3'd5, v); chk("R8 divided rate", v, 32'(16 >> r));
    end
    post(3'd0, 32'h0C);
    fresh_trig();
    tick(16);
    rd(3'd5, v); chk("R8 disabled ignores ratio", v, 32'd16);
    rd(3'd0, v); chk("R2 ctrl readback", v, 32'h0C);

    // R5 stop and R7 hold
    post(3'd3, 32'hAAAA);
    post(3'd3, 32'h5555);
    rd(3'd6, v); chk("R5 stopped", v, 0);
    rd(3'd5, c0);
    tick(5);
    rd(3'd5, v); chk("R7 holds while stopped", v, c0);

    // R6 broken sequences
    post(3'd3, 32'hBBBB);
    post(3'd3, 32'h1234);
    post(3'd3, 32'h4444);
    rd(3'd6, v); chk("R6 broken start", v, 0);
    post(3'd3, 32'hAAAA);
    post(3'd3, 32'hBBBB);
    post(3'd3, 32'h4444);
    rd(3'd6, v); chk("R6 restart after break", v, 1);
    rd(3'd5, c0);
    tick(4);
    rd(3'd5, v); chk("R7 counts while running", v, c0 + 4);
    post(3'd3, 32'hBBBB);
    post(3'd3, 32'hAAAA);
    post(3'd3, 32'h5555);
    rd(3'd6, v); chk("R6 stop after broken start", v, 0);
    rd(3'd4, v); chk("R2 status idle at end", v, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule